// File: doc/BRIEF.md
# Interrupt Claim-Complete Register Block

This block collects level-sensitive interrupt lines and presents them to a small set of contexts. Each context stands for one hart running in one privilege mode. Software reaches the block over a plain 32-bit register bus with these signals: address, write strobe, write data, read strobe and combinational read data. Through that bus it programs a priority for each source, an enable mask for each context and a threshold for each context.

For every context, a separate selector block picks the best eligible source. The block then raises that context's interrupt request line. A handler reads the context's claim word to learn which source won. That read also moves the source from pending to claimed, so no context offers it again. When service is done, the handler writes the source number back to the same word to release it. Source number 0 is reserved to mean "nothing to service", and it has no priority register.

Only aligned 32-bit accesses are decoded. Any address that is misaligned, unmapped or otherwise unused reads as zero and changes nothing. With the default parameters the map is:

- priority words from 0x000
- pending words from 0x080
- one 0x20-byte enable window per context from 0x100
- one 0x10-byte control window per context from 0x200

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset every priority, threshold, enable, pending and claimed bit is zero, every `irq_req_o` bit is low, and every mapped register reads 0.
- R2: The priority of source n (1 to NUM_SRC-1) is at byte address PRIO_BASE+(n-1)*4. A write keeps only data bits [2:0], and a read returns them zero-extended.
- R3: Source n's pending bit is bit n%32 of the pending word at PEND_BASE+(n/32)*4. When a source input differs from its value on the previous clock, the pending bit takes the new level. Pending bit 0 is always 0. Writes to the pending words are ignored.
- R4: Context c's enable word w is at ENA_BASE+c*ENA_STRIDE+w*4, and bit n%32 of word n/32 enables source n. Word indices at or beyond the number of pending words read 0 and ignore writes. Bits for sources that do not exist read 0.
- R5: Context c's threshold is at CTX_BASE+c*CTX_STRIDE+0. A write is stored only when the full 32-bit value is at most NUM_LVL (7). A larger value leaves the old threshold in place.
- R6: A context's selected source is the one with the highest priority among sources that are pending, enabled for that context, not claimed, and whose priority is strictly greater than the context's threshold. Equal priorities resolve to the lowest ID. The result is 0 when no source qualifies.
- R7: A read at CTX_BASE+c*CTX_STRIDE+4 returns context c's selected ID. When that ID is nonzero, the same read clears its pending bit and sets its claimed bit, so the source cannot be selected again until it is completed.
- R8: A write at CTX_BASE+c*CTX_STRIDE+4 clears the claimed bit of the source whose ID equals the written value, provided the value is below NUM_SRC. Larger values are ignored.
- R9: `irq_req_o[c]` is a register. It is high exactly when context c's selection, as computed from the state of the previous cycle, is nonzero, so it follows any state change by one clock.
- R10: Misaligned addresses, addresses outside every region, and context offsets other than 0 and 4 read 0 and change no state when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | NUM_SRC | Level interrupt inputs; bit 0 is unused |
| bus_addr_i | input | AW | Byte address of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe; a claim read takes effect at the clock edge |
| bus_rdata_o | output | 32 | Read data, combinational, zero when no read is active |
| irq_req_o | output | NUM_CTX | Registered interrupt request, one per context |

## Verification
Selection is swept over all 256 patterns on the eight input lines. The priority map is fixed and contains two ties, a source below the context threshold and a source at priority zero, and the two contexts use different enable masks. For each pattern the context's claim word is read repeatedly until it returns 0. This shows that selection order follows priority and then ID, and that a claimed source drops out. A source that is held claimed while its line toggles separates a rejected completion (ID out of range) from an accepted one. The request-line timing is checked on the exact clock after an enable write. The threshold is swept across values just below and just above the level count. Writes to every unused address form are shown to leave mapped registers unchanged.

// File: rtl/irq_claim_pkg.sv
`timescale 1ns/1ps
package irq_claim_pkg;

    // Register region an access decodes to.
    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_ENA,
        RG_THR,
        RG_CLAIM
    } region_e;

    // Result of address decode; indices are plain 32-bit values.
    typedef struct packed {
        region_e     rg;
        logic [31:0] src;
        logic [31:0] word;
        logic [31:0] ctx;
    } decode_t;

endpackage

// File: rtl/irq_claim_gate.sv
`timescale 1ns/1ps
// Pending-bit capture: each bit follows its line on a level change,
// and a claim clears it while the line is unchanged.
module irq_claim_gate #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] last;
        logic [NUM_SRC-1:0] pend;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.last = lvl_i;
        for (int n = 0; n < int'(NUM_SRC); n++) begin
            if (n == 0) begin
                g_d.pend[n] = 1'b0;
            end else if (lvl_i[n] != g_q.last[n]) begin
                g_d.pend[n] = lvl_i[n];
            end else if (clr_i[n]) begin
                g_d.pend[n] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign pend_o = g_q.pend;

    for (genvar n = 1; n < NUM_SRC; n++) begin : g_chk
        assert_pend_follows_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lvl_i[n] != g_q.last[n]) |=> (pend_o[n] == $past(lvl_i[n])));
        assert_claim_clears_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[n] && (lvl_i[n] == g_q.last[n])) |=> !pend_o[n]);
    end

    assert_src0_idle_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_o[0]);

endmodule

// File: rtl/irq_claim_pick.sv
`timescale 1ns/1ps
// Per-context winner selection: highest priority above threshold,
// lowest ID on a tie, 0 when nothing qualifies.
module irq_claim_pick #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned PRIO_W  = 3,
    localparam int unsigned IDW    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             claimed_i,
    input  logic [NUM_SRC-1:0]             ena_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [IDW-1:0]                 id_o
);

    logic [PRIO_W-1:0] best_p;

    always_comb begin
        id_o   = '0;
        best_p = thr_i;
        for (int n = 1; n < int'(NUM_SRC); n++) begin
            if (pend_i[n] && !claimed_i[n] && ena_i[n] && (prio_i[n] > best_p)) begin
                id_o   = IDW'(n);
                best_p = prio_i[n];
            end
        end
    end

endmodule

// File: rtl/irq_claim_ctrl.sv
`timescale 1ns/1ps
module irq_claim_ctrl
    import irq_claim_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 8,
    parameter int unsigned NUM_CTX    = 2,
    parameter int unsigned PRIO_W     = 3,
    parameter int unsigned NUM_LVL    = 7,
    parameter int unsigned AW         = 12,
    parameter int unsigned PRIO_BASE  = 'h000,
    parameter int unsigned PEND_BASE  = 'h080,
    parameter int unsigned ENA_BASE   = 'h100,
    parameter int unsigned ENA_STRIDE = 'h20,
    parameter int unsigned CTX_BASE   = 'h200,
    parameter int unsigned CTX_STRIDE = 'h10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic [AW-1:0]      bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [31:0]        bus_wdata_i,
    input  logic               bus_rd_i,
    output logic [31:0]        bus_rdata_o,
    output logic [NUM_CTX-1:0] irq_req_o
);

    localparam int unsigned IDW      = $clog2(NUM_SRC);
    localparam int unsigned CTXW     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int unsigned BF_WORDS = (NUM_SRC + 31) / 32;
    localparam int unsigned PAD_W    = BF_WORDS * 32;
    localparam int unsigned ENA_SH   = $clog2(ENA_STRIDE);
    localparam int unsigned CTX_SH   = $clog2(CTX_STRIDE);

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0]  prio;
        logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
        logic [NUM_CTX-1:0][NUM_SRC-1:0] ena;
        logic [NUM_SRC-1:0]              claimed;
        logic [NUM_CTX-1:0]              irq;
    } state_t;

    state_t st_d, st_q;

    decode_t                      dec;
    logic [31:0]                  addr_w;
    logic [31:0]                  off_w;
    logic [NUM_SRC-1:0]           pend;
    logic [NUM_SRC-1:0]           claim_clr;
    logic [NUM_CTX-1:0][IDW-1:0]  sel_id;
    logic [IDW-1:0]               claim_id;
    logic [PAD_W-1:0]             pend_pad;
    logic [PAD_W-1:0]             rd_ena_pad;
    logic [CTXW-1:0]              dctx;
    logic [IDW-1:0]               dsrc;

    // ---------------------------------------------------------------
    // Address decode
    // ---------------------------------------------------------------
    always_comb begin
        addr_w = 32'(bus_addr_i);
        off_w  = '0;
        dec    = '{rg: RG_NONE, src: '0, word: '0, ctx: '0};
        if (addr_w[1:0] == 2'b00) begin
            if (addr_w >= PRIO_BASE && (addr_w - PRIO_BASE) < (NUM_SRC - 1) * 4) begin
                off_w   = addr_w - PRIO_BASE;
                dec.rg  = RG_PRIO;
                dec.src = (off_w >> 2) + 32'd1;
            end else if (addr_w >= PEND_BASE && (addr_w - PEND_BASE) < BF_WORDS * 4) begin
                off_w    = addr_w - PEND_BASE;
                dec.rg   = RG_PEND;
                dec.word = off_w >> 2;
            end else if (addr_w >= ENA_BASE && (addr_w - ENA_BASE) < NUM_CTX * ENA_STRIDE) begin
                off_w    = addr_w - ENA_BASE;
                dec.ctx  = off_w >> ENA_SH;
                dec.word = (off_w & (ENA_STRIDE - 1)) >> 2;
                if (dec.word < BF_WORDS) begin
                    dec.rg = RG_ENA;
                end
            end else if (addr_w >= CTX_BASE && (addr_w - CTX_BASE) < NUM_CTX * CTX_STRIDE) begin
                off_w   = addr_w - CTX_BASE;
                dec.ctx = off_w >> CTX_SH;
                if ((off_w & (CTX_STRIDE - 1)) == 32'd0) begin
                    dec.rg = RG_THR;
                end else if ((off_w & (CTX_STRIDE - 1)) == 32'd4) begin
                    dec.rg = RG_CLAIM;
                end
            end
        end
    end

    assign dctx = dec.ctx[CTXW-1:0];
    assign dsrc = dec.src[IDW-1:0];

    // ---------------------------------------------------------------
    // Pending capture and per-context selection
    // ---------------------------------------------------------------
    irq_claim_gate #(
        .NUM_SRC (NUM_SRC)
    ) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (irq_src_i),
        .clr_i  (claim_clr),
        .pend_o (pend)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irq_claim_pick #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W)
        ) u_pick (
            .pend_i    (pend),
            .claimed_i (st_q.claimed),
            .ena_i     (st_q.ena[c]),
            .prio_i    (st_q.prio),
            .thr_i     (st_q.thr[c]),
            .id_o      (sel_id[c])
        );
    end

    assign claim_id = sel_id[dctx];
    assign pend_pad = PAD_W'(pend);

    // ---------------------------------------------------------------
    // Read data
    // ---------------------------------------------------------------
    always_comb begin
        bus_rdata_o = '0;
        rd_ena_pad  = PAD_W'(st_q.ena[dctx]);
        if (bus_rd_i) begin
            unique case (dec.rg)
                RG_PRIO:  bus_rdata_o = 32'(st_q.prio[dsrc]);
                RG_PEND:  bus_rdata_o = pend_pad[dec.word*32 +: 32];
                RG_ENA:   bus_rdata_o = rd_ena_pad[dec.word*32 +: 32];
                RG_THR:   bus_rdata_o = 32'(st_q.thr[dctx]);
                RG_CLAIM: bus_rdata_o = 32'(claim_id);
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        st_d      = st_q;
        claim_clr = '0;

        if (bus_rd_i && (dec.rg == RG_CLAIM) && (claim_id != '0)) begin
            st_d.claimed[claim_id] = 1'b1;
            claim_clr[claim_id]    = 1'b1;
        end

        if (bus_wr_i) begin
            unique case (dec.rg)
                RG_PRIO: begin
                    st_d.prio[dsrc] = bus_wdata_i[PRIO_W-1:0];
                end
                RG_ENA: begin
                    for (int n = 0; n < int'(NUM_SRC); n++) begin
                        if (32'(n / 32) == dec.word) begin
                            st_d.ena[dctx][n] = bus_wdata_i[n % 32];
                        end
                    end
                end
                RG_THR: begin
                    if (bus_wdata_i <= NUM_LVL) begin
                        st_d.thr[dctx] = bus_wdata_i[PRIO_W-1:0];
                    end
                end
                RG_CLAIM: begin
                    if (bus_wdata_i < NUM_SRC) begin
                        st_d.claimed[bus_wdata_i[IDW-1:0]] = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end

        for (int c = 0; c < int'(NUM_CTX); c++) begin
            st_d.irq[c] = (sel_id[c] != '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req_o = st_q.irq;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    assert_thr_reject_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (dec.rg == RG_THR) && (bus_wdata_i > NUM_LVL))
            |=> (st_q.thr == $past(st_q.thr)));

    assert_claim_marks_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && (dec.rg == RG_CLAIM) && (claim_id != '0))
            |=> st_q.claimed[$past(claim_id)]);

    assert_unmapped_quiet_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (dec.rg == RG_NONE))
            |=> ($stable(st_q.prio) && $stable(st_q.ena) && $stable(st_q.thr)));

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_chk
        assert_pick_eligible_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel_id[c] != '0) |-> (pend[sel_id[c]] && !st_q.claimed[sel_id[c]] &&
                                   st_q.ena[c][sel_id[c]] &&
                                   (st_q.prio[sel_id[c]] > st_q.thr[c])));
        assert_irq_lags_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> (irq_req_o[c] == $past(sel_id[c] != '0)));
    end

endmodule

// File: tb/irq_claim_ctrl_tb.sv
`timescale 1ns/1ps
module irq_claim_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_cmp = 0;
    int n_err = 0;

    // Fixed priority map used by the selection sweep; includes ties.
    int PR [8] = '{0, 3, 5, 5, 1, 7, 2, 7};
    localparam logic [7:0] E0 = 8'hFE;
    localparam logic [7:0] E1 = 8'h5A;
    localparam int T0 = 2;
    localparam int T1 = 0;

    always #10 clk = ~clk;

    irq_claim_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_src_i   (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_req_o   (irq)
    );

    function automatic logic [11:0] a_prio(int n);  return 12'((n - 1) * 4); endfunction
    function automatic logic [11:0] a_ena(int c, int w); return 12'('h100 + c * 'h20 + w * 4); endfunction
    function automatic logic [11:0] a_thr(int c);   return 12'('h200 + c * 'h10); endfunction
    function automatic logic [11:0] a_clm(int c);   return 12'('h204 + c * 'h10); endfunction
    localparam logic [11:0] A_PEND = 12'h080;

    function automatic int exp_pick(logic [7:0] pm, logic [7:0] cm, logic [7:0] en, int th);
        int best = th;
        int id = 0;
        for (int n = 1; n < 8; n++) begin
            if (pm[n] && !cm[n] && en[n] && PR[n] > best) begin
                best = PR[n];
                id = n;
            end
        end
        return id;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Tasks start and end just after a falling edge.
    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        #5;
        d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] prev;
        logic [7:0]  pm;
        logic [7:0]  cm;
        int e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", 32'(irq), 0);
        for (int n = 1; n < 8; n++) begin rd_reg(a_prio(n), d); chk("R1 prio", d, 0); end
        for (int c = 0; c < 2; c++) begin
            rd_reg(a_thr(c), d);    chk("R1 thr", d, 0);
            rd_reg(a_ena(c, 0), d); chk("R1 ena", d, 0);
            rd_reg(a_clm(c), d);    chk("R1 claim", d, 0);
        end
        rd_reg(A_PEND, d); chk("R1 pend", d, 0);

        // R3: pending follows inputs, read-only, bit 0 never set
        for (int p = 0; p < 256; p++) begin
            src = 8'(p);
            @(negedge clk);
            rd_reg(A_PEND, d); chk("R3 pend", d, 32'(p & 'hFE));
            wr_reg(A_PEND, ~32'(p));
            rd_reg(A_PEND, d); chk("R3 pend write ignored", d, 32'(p & 'hFE));
        end
        src = '0;
        @(negedge clk);
        rd_reg(A_PEND, d); chk("R3 pend falls", d, 0);

        // R2: priority keeps low three bits
        for (int n = 1; n < 8; n++) wr_reg(a_prio(n), 32'hFFFF_FFF8 | 32'((n * 5) & 7));
        for (int n = 1; n < 8; n++) begin rd_reg(a_prio(n), d); chk("R2 prio", d, 32'((n * 5) & 7)); end

        // R4: enable windows
        wr_reg(a_ena(0, 0), 32'hFFFF_FFFF);
        rd_reg(a_ena(0, 0), d); chk("R4 ena width", d, 32'h0000_00FF);
        wr_reg(a_ena(0, 1), 32'h0000_1234);
        rd_reg(a_ena(0, 1), d); chk("R4 ena word beyond", d, 0);
        rd_reg(a_ena(0, 0), d); chk("R4 ena unchanged", d, 32'h0000_00FF);
        rd_reg(a_ena(1, 0), d); chk("R4 ena other ctx", d, 0);

        // R5: threshold accept/reject sweep
        prev = 0;
        for (int v = 0; v < 11; v++) begin
            wr_reg(a_thr(1), 32'(v));
            if (v <= 7) prev = 32'(v);
            rd_reg(a_thr(1), d); chk("R5 thr", d, prev);
        end
        wr_reg(a_thr(1), 32'h8000_0003);
        rd_reg(a_thr(1), d); chk("R5 thr wide reject", d, prev);

        // Configure for selection sweep
        for (int n = 1; n < 8; n++) wr_reg(a_prio(n), 32'(PR[n]));
        wr_reg(a_ena(0, 0), 32'(E0));
        wr_reg(a_ena(1, 0), 32'(E1));
        wr_reg(a_thr(0), 32'(T0));
        wr_reg(a_thr(1), 32'(T1));

        // R10: unused address forms
        wr_reg(12'h01C, 32'hFFFF_FFFF);
        wr_reg(12'h084, 32'hFFFF_FFFF);
        wr_reg(12'h140, 32'hFFFF_FFFF);
        wr_reg(12'h001, 32'hFFFF_FFFF);
        wr_reg(12'h208, 32'hFFFF_FFFF);
        wr_reg(12'h300, 32'hFFFF_FFFF);
        rd_reg(12'h01C, d); chk("R10 unmapped read", d, 0);
        rd_reg(12'h001, d); chk("R10 misaligned read", d, 0);
        rd_reg(12'h208, d); chk("R10 ctx offset 8 read", d, 0);
        rd_reg(a_prio(1), d); chk("R10 prio kept", d, 32'(PR[1]));
        rd_reg(a_thr(0), d);  chk("R10 thr kept", d, 32'(T0));
        rd_reg(a_ena(1, 0), d); chk("R10 ena kept", d, 32'(E1));

        // R6/R7/R9: every input pattern, drain claims
        for (int p = 0; p < 256; p++) begin
            src = '0;
            @(negedge clk);
            src = 8'(p);
            @(negedge clk);
            @(negedge clk);
            pm = 8'(p) & 8'hFE;
            cm = '0;
            chk("R9 irq ctx0", 32'(irq[0]), 32'(exp_pick(pm, cm, E0, T0) != 0));
            chk("R9 irq ctx1", 32'(irq[1]), 32'(exp_pick(pm, cm, E1, T1) != 0));
            for (int k = 0; k < 8; k++) begin
                e = exp_pick(pm, cm, E0, T0);
                rd_reg(a_clm(0), d); chk("R6 R7 claim ctx0", d, 32'(e));
                if (e == 0) break;
                pm[e] = 1'b0;
                cm[e] = 1'b1;
            end
            e = exp_pick(pm, cm, E1, T1);
            rd_reg(a_clm(1), d); chk("R6 R7 claim ctx1", d, 32'(e));
            if (e != 0) cm[e] = 1'b1;
            for (int n = 1; n < 8; n++) if (cm[n]) wr_reg(a_clm(0), 32'(n));
        end

        // R8: out-of-range completion ignored, valid one releases
        src = '0; @(negedge clk);
        src = 8'h08; @(negedge clk); @(negedge clk);
        rd_reg(a_clm(0), d); chk("R8 first claim", d, 3);
        wr_reg(a_clm(0), 32'd11);
        src = '0; @(negedge clk);
        src = 8'h08; @(negedge clk); @(negedge clk);
        chk("R8 irq held while claimed", 32'(irq[0]), 0);
        rd_reg(a_clm(0), d); chk("R8 claimed not offered", d, 0);
        wr_reg(a_clm(0), 32'd3);
        @(negedge clk);
        chk("R8 irq after completion", 32'(irq[0]), 1);
        rd_reg(a_clm(0), d); chk("R8 reclaim", d, 3);
        wr_reg(a_clm(0), 32'd3);

        // R9: one-cycle latency after an enable write
        src = '0; @(negedge clk);
        src = 8'h80; @(negedge clk); @(negedge clk);
        chk("R9 ctx1 idle before", 32'(irq[1]), 0);
        wr_reg(a_ena(1, 0), 32'h80);
        chk("R9 ctx1 not yet", 32'(irq[1]), 0);
        @(negedge clk);
        chk("R9 ctx1 raised", 32'(irq[1]), 1);
        rd_reg(a_clm(1), d); chk("R7 claim ctx1", d, 7);
        @(negedge clk);
        chk("R9 ctx1 dropped", 32'(irq[1]), 0);
        wr_reg(a_clm(1), 32'd7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule